// File: doc/BRIEF.md
# UART Register Bank Decoder

This block is the processor-facing register file of one 16550-style serial channel. A host drives a 3-bit register address together with a read strobe, a write strobe and a byte of write data. The block steers every access to the register it names. The divisor-latch access bit, bit 7 of the line control register, swaps the bank seen at the two lowest addresses. The block stores the interrupt enable, line control, modem control, scratch and divisor bytes, together with the kept fields of the FIFO control byte. It returns the live line-status and modem-status vectors on reads.

The shifters, baud generator and FIFOs sit outside the block. They meet it only through plain one-cycle strobes: a receive-pop strobe, a transmit-push strobe with its byte, and two FIFO-flush pulses. They also supply the status vectors that the block reads back. None of these paths carries valid/ready back-pressure. A strobe is a single-cycle event that the neighbouring logic must accept in the cycle it appears. The host may assert `rd_en` and `wr_en` in the same cycle. Both then take effect.

Top module: `uart_regbank`

## Requirements
- R1: After an active-low reset, every stored field is 0 (`ier_o`, `lcr_o`, `mcr_o`, `dll_o`, `dlm_o`, `fifo_en`, `fifo_dma` are all 0). A read of address 2 with `intr_pend` low and `intr_id` 0 returns 0x01.
- R2: With `lcr_o[7]`=0, a read of address 0 returns `rx_data` and raises `rx_pop` in that same cycle. A write to address 0 raises `tx_push` in that cycle, with `tx_data` equal to `wdata`. Neither strobe rises without its own access, and `rdata` is 0 while `rd_en` is low.
- R3: With `lcr_o[7]`=1, address 0 reads and writes the divisor low byte and address 1 reads and writes the divisor high byte. In this bank, `rx_pop` and `tx_push` stay low.
- R4: With `lcr_o[7]`=0, address 1 is the interrupt enable register. Only bits 3:0 are stored, and bits 7:4 read as 0.
- R5: A read of address 2 returns {fifo_en, fifo_en, 2'b00, intr_id[2:0], ~intr_pend}. A write to address 2 stores `fifo_en`=wdata[0], `fifo_dma`=wdata[3] and the trigger select from wdata[7:6]. In the same cycle it raises `rx_flush` if wdata[1] is 1 and `tx_flush` if wdata[2] is 1.
- R6: `rx_trig_lvl` decodes the stored trigger select as follows: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R7: Address 3 (line control) reads and writes all 8 bits. Address 4 (modem control) stores bits 4:0 and reads bits 7:5 as 0. Address 7 (scratch) reads and writes all 8 bits. All three behave the same in both banks.
- R8: Address 5 reads `line_stat` and address 6 reads `modem_stat`. A write to either address changes no stored field.
- R9: Stored fields change at the clock edge that ends the write. A read in the same cycle as a write sees the fields and the bank as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when idle |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_pop | output | 1 | Receive-pop strobe |
| tx_push | output | 1 | Transmit-push strobe |
| tx_data | output | 8 | Byte pushed with `tx_push` |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| intr_id | input | 3 | Identifier of the highest pending interrupt |
| intr_pend | input | 1 | An interrupt is pending |
| line_stat | input | 8 | Line status vector |
| modem_stat | input | 8 | Modem status vector |
| ier_o | output | 4 | Interrupt enables |
| lcr_o | output | 8 | Line control byte |
| mcr_o | output | 5 | Modem control bits |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |
| fifo_en | output | 1 | FIFO enable |
| fifo_dma | output | 1 | FIFO DMA mode select |
| rx_trig_lvl | output | 4 | Receive trigger depth in characters |

## Verification
A read and a write can land in the same cycle. The case that matters most is a write to the line control register that flips the bank bit while a read of address 0 or 1 decodes against the old bank. The random stream sets `rd_en` and `wr_en` independently, so collisions of this kind occur often. Directed cases add a read and a write to address 0 together, which must raise `rx_pop` and `tx_push` at once. The bench keeps its own register model, updated only at the clock edge. It judges each read by the model's value before the edge and each stored field by the model's value after the edge.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  parameter int DW    = 8;
  parameter int AW    = 3;
  parameter int IERW  = 4;
  parameter int MCRW  = 5;
  parameter int TRGW  = 4;
  localparam int NSLOT = 1 << AW;

  typedef enum logic [AW-1:0] {
    A_DATA = 3'd0,
    A_IEN  = 3'd1,
    A_IFC  = 3'd2,
    A_LCTL = 3'd3,
    A_MCTL = 3'd4,
    A_LST  = 3'd5,
    A_MST  = 3'd6,
    A_SCR  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [IERW-1:0] ier;
    logic [DW-1:0]   lcr;
    logic [MCRW-1:0] mcr;
    logic [DW-1:0]   spr;
    logic [DW-1:0]   dll;
    logic [DW-1:0]   dlm;
    logic            fen;
    logic            dma;
    logic [1:0]      trig;
  } ctrl_regs_t;

  typedef struct packed {
    logic dll;
    logic dlm;
    logic ier;
    logic fcr;
    logic lcr;
    logic mcr;
    logic spr;
  } wr_sel_t;

  function automatic logic [TRGW-1:0] trig_depth(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_depth = TRGW'(1);
      2'b01:   trig_depth = TRGW'(4);
      2'b10:   trig_depth = TRGW'(8);
      default: trig_depth = TRGW'(14);
    endcase
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          dlab,
  output wr_sel_t       we,
  output logic          rx_pop,
  output logic          tx_push
);
  logic [NSLOT-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_hit
      assign hit[g] = (addr == AW'(g));
    end
  endgenerate

  always_comb begin
    we     = '0;
    we.dll = wr_en &  dlab & hit[A_DATA];
    we.dlm = wr_en &  dlab & hit[A_IEN];
    we.ier = wr_en & ~dlab & hit[A_IEN];
    we.fcr = wr_en & hit[A_IFC];
    we.lcr = wr_en & hit[A_LCTL];
    we.mcr = wr_en & hit[A_MCTL];
    we.spr = wr_en & hit[A_SCR];
  end

  assign rx_pop  = rd_en & ~dlab & hit[A_DATA];
  assign tx_push = wr_en & ~dlab & hit[A_DATA];
endmodule

// File: rtl/uart_rb_store.sv
module uart_rb_store
  import uart_rb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  wr_sel_t       we,
  input  logic [DW-1:0] wdata,
  output ctrl_regs_t    q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (we.ier) q.ier <= wdata[IERW-1:0];
      if (we.lcr) q.lcr <= wdata;
      if (we.mcr) q.mcr <= wdata[MCRW-1:0];
      if (we.spr) q.spr <= wdata;
      if (we.dll) q.dll <= wdata;
      if (we.dlm) q.dlm <= wdata;
      if (we.fcr) begin
        q.fen  <= wdata[0];
        q.dma  <= wdata[3];
        q.trig <= wdata[7:6];
      end
    end
  end

  AST_SPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we.spr |=> $stable(q.spr)); // R7
  AST_DLL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we.dll |=> (q.dll == $past(wdata))); // R3
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
  import uart_rb_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          dlab,
  input  ctrl_regs_t    q,
  input  logic [DW-1:0] rx_data,
  input  logic [2:0]    intr_id,
  input  logic          intr_pend,
  input  logic [DW-1:0] line_stat,
  input  logic [DW-1:0] modem_stat,
  output logic [DW-1:0] val
);
  always_comb begin
    case (addr)
      A_DATA:  val = dlab ? q.dll : rx_data;
      A_IEN:   val = dlab ? q.dlm : {{(DW-IERW){1'b0}}, q.ier};
      A_IFC:   val = {q.fen, q.fen, 2'b00, intr_id, ~intr_pend};
      A_LCTL:  val = q.lcr;
      A_MCTL:  val = {{(DW-MCRW){1'b0}}, q.mcr};
      A_LST:   val = line_stat;
      A_MST:   val = modem_stat;
      default: val = q.spr;
    endcase
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [DW-1:0]   rx_data,
  output logic            rx_pop,
  output logic            tx_push,
  output logic [DW-1:0]   tx_data,
  output logic            rx_flush,
  output logic            tx_flush,
  input  logic [2:0]      intr_id,
  input  logic            intr_pend,
  input  logic [DW-1:0]   line_stat,
  input  logic [DW-1:0]   modem_stat,
  output logic [IERW-1:0] ier_o,
  output logic [DW-1:0]   lcr_o,
  output logic [MCRW-1:0] mcr_o,
  output logic [DW-1:0]   dll_o,
  output logic [DW-1:0]   dlm_o,
  output logic            fifo_en,
  output logic            fifo_dma,
  output logic [TRGW-1:0] rx_trig_lvl
);
  wr_sel_t       we;
  ctrl_regs_t    q;
  logic [DW-1:0] rd_val;
  logic          dlab;

  assign dlab = q.lcr[DW-1];

  uart_rb_decode u_dec (
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .dlab    (dlab),
    .we      (we),
    .rx_pop  (rx_pop),
    .tx_push (tx_push)
  );

  uart_rb_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .wdata (wdata),
    .q     (q)
  );

  uart_rb_rdmux u_rmux (
    .addr       (addr),
    .dlab       (dlab),
    .q          (q),
    .rx_data    (rx_data),
    .intr_id    (intr_id),
    .intr_pend  (intr_pend),
    .line_stat  (line_stat),
    .modem_stat (modem_stat),
    .val        (rd_val)
  );

  assign rdata       = rd_en ? rd_val : '0;
  assign tx_data     = tx_push ? wdata : '0;
  assign rx_flush    = we.fcr & wdata[1];
  assign tx_flush    = we.fcr & wdata[2];
  assign ier_o       = q.ier;
  assign lcr_o       = q.lcr;
  assign mcr_o       = q.mcr;
  assign dll_o       = q.dll;
  assign dlm_o       = q.dlm;
  assign fifo_en     = q.fen;
  assign fifo_dma    = q.dma;
  assign rx_trig_lvl = trig_depth(q.trig);

  AST_TX_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !lcr_o[DW-1]); // R2
  AST_ISR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_IFC && !intr_pend) |-> rdata[0]); // R5
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_LST || addr == A_MST)) |=> $stable(q)); // R8
  AST_FLUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush || tx_flush) |-> (wr_en && addr == A_IFC)); // R5
endmodule

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
  localparam int CLK_PER = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] addr = 0;
  logic       rd_en = 0, wr_en = 0;
  logic [7:0] wdata = 0, rdata, rx_data = 0, tx_data, line_stat = 0, modem_stat = 0;
  logic       rx_pop, tx_push, rx_flush, tx_flush, intr_pend = 0, fifo_en, fifo_dma;
  logic [2:0] intr_id = 0;
  logic [3:0] ier_o, rx_trig_lvl;
  logic [7:0] lcr_o, dll_o, dlm_o;
  logic [4:0] mcr_o;

  int total = 0, bad = 0;

  logic [3:0] m_ier; logic [7:0] m_lcr, m_spr, m_dll, m_dlm;
  logic [4:0] m_mcr; logic m_fen, m_dma; logic [1:0] m_trig;

  always #(CLK_PER/2) clk = ~clk;

  uart_regbank uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_pop(rx_pop),
    .tx_push(tx_push), .tx_data(tx_data), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .intr_id(intr_id), .intr_pend(intr_pend), .line_stat(line_stat),
    .modem_stat(modem_stat), .ier_o(ier_o), .lcr_o(lcr_o), .mcr_o(mcr_o),
    .dll_o(dll_o), .dlm_o(dlm_o), .fifo_en(fifo_en), .fifo_dma(fifo_dma),
    .rx_trig_lvl(rx_trig_lvl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_trig(input logic [1:0] s);
    case (s)
      2'b00: return 4'd1;
      2'b01: return 4'd4;
      2'b10: return 4'd8;
      default: return 4'd14;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic dl = m_lcr[7];
    case (a)
      3'd0: return dl ? m_dll : rx_data;
      3'd1: return dl ? m_dlm : {4'b0, m_ier};
      3'd2: return {m_fen, m_fen, 2'b00, intr_id, ~intr_pend};
      3'd3: return m_lcr;
      3'd4: return {3'b0, m_mcr};
      3'd5: return line_stat;
      3'd6: return modem_stat;
      default: return m_spr;
    endcase
  endfunction

  task automatic model_reset();
    m_ier = 0; m_lcr = 0; m_spr = 0; m_dll = 0; m_dlm = 0;
    m_mcr = 0; m_fen = 0; m_dma = 0; m_trig = 0;
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    logic dl = m_lcr[7];
    case (a)
      3'd0: if (dl) m_dll = d;
      3'd1: if (dl) m_dlm = d; else m_ier = d[3:0];
      3'd2: begin m_fen = d[0]; m_dma = d[3]; m_trig = d[7:6]; end
      3'd3: m_lcr = d;
      3'd4: m_mcr = d[4:0];
      3'd7: m_spr = d;
      default: ;
    endcase
  endtask

  task automatic check_fields(input string req);
    check({req, " ier"}, ier_o, m_ier);
    check({req, " lcr"}, lcr_o, m_lcr);
    check({req, " mcr"}, mcr_o, m_mcr);
    check({req, " dll"}, dll_o, m_dll);
    check({req, " dlm"}, dlm_o, m_dlm);
    check({req, " fifo"}, {fifo_en, fifo_dma}, {m_fen, m_dma});
    check("R6 trig", rx_trig_lvl, exp_trig(m_trig));
  endtask

  // one bus cycle: drive at negedge, judge combinational outputs, then the edge
  task automatic access(input logic r, input logic w, input logic [2:0] a,
                        input logic [7:0] d, input string req);
    logic dl;
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wdata = d;
    #1;
    dl = m_lcr[7];
    check({req, " rdata"}, rdata, r ? exp_read(a) : 8'h00);
    check("R2 rx_pop", rx_pop, r && a == 3'd0 && !dl);
    check("R2 tx_push", tx_push, w && a == 3'd0 && !dl);
    if (w && a == 3'd0 && !dl) check("R2 tx_data", tx_data, d);
    check("R5 rx_flush", rx_flush, w && a == 3'd2 && d[1]);
    check("R5 tx_flush", tx_flush, w && a == 3'd2 && d[2]);
    @(posedge clk);
    if (w) model_write(a, d);
    #1;
    rd_en = 0; wr_en = 0;
    check_fields({req, " R9"});
  endtask

  initial begin
    #(CLK_PER * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check_fields("R1 reset");
    access(1, 0, 3'd2, 8'h00, "R1 isr idle");

    // R4 / R7 directed
    access(0, 1, 3'd1, 8'hFF, "R4 ier wr");
    access(1, 0, 3'd1, 8'h00, "R4 ier rd");
    access(0, 1, 3'd4, 8'hFF, "R7 mcr wr");
    access(1, 0, 3'd4, 8'h00, "R7 mcr rd");
    access(0, 1, 3'd7, 8'hA5, "R7 spr wr");
    // R8: writes to status addresses
    access(0, 1, 3'd5, 8'h3C, "R8 lsr wr");
    access(0, 1, 3'd6, 8'hC3, "R8 msr wr");
    line_stat = 8'h61; modem_stat = 8'hB0;
    access(1, 0, 3'd5, 8'h00, "R8 lsr rd");
    access(1, 0, 3'd6, 8'h00, "R8 msr rd");
    // R6 trigger decode for every select
    for (int s = 0; s < 4; s++) access(0, 1, 3'd2, {s[1:0], 6'b000111}, "R6 fcr");
    // R2 simultaneous pop and push
    rx_data = 8'h5A;
    access(1, 1, 3'd0, 8'h77, "R2 pop+push");
    // R3 divisor bank, with bank switch colliding with a read (R9)
    access(1, 1, 3'd3, 8'h83, "R9 lcr dlab");
    access(1, 1, 3'd0, 8'h12, "R3 dll");
    access(1, 1, 3'd1, 8'h34, "R3 dlm");
    access(1, 0, 3'd7, 8'h00, "R7 spr bank1");
    access(1, 1, 3'd3, 8'h03, "R9 lcr back");
    access(1, 0, 3'd1, 8'h00, "R4 ier after");

    // random phase
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] a;
      rx_data    = 8'($urandom);
      line_stat  = 8'($urandom);
      modem_stat = 8'($urandom);
      intr_id    = 3'($urandom);
      intr_pend  = 1'($urandom);
      a = 3'($urandom);
      access(1'($urandom), 1'($urandom), a, 8'($urandom), "R9 rand");
    end

    // R1 reset again from a dirty state
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    model_reset();
    @(negedge clk); rst_n = 1; #1;
    check_fields("R1 rereset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule